// File: doc/BRIEF.md
# Programmable Parallel Display Bus Timer

This block sequences single accesses on an asynchronous parallel display-controller bus of the 8080/6800 kind, for one chip select. Each access comes in through a ready/valid request carrying a read/write flag, a command/address bit and write data. The block then walks the bus through a setup phase, an active-low strobe, a hold phase and, where required, an idle gap. It drives chip select, the command line, the direction line, the data output enable and the data bus.

All phase lengths are counted in cycles of the module clock and come from one 32-bit timing word. Reads and writes have separate setup, strobe and hold counts; a single gap count sets the idle time between accesses. The gap is skipped only when a read directly follows a read. The timing word is captured when a request is accepted, so software may rewrite it while an access is in flight. For reads, the data bus is sampled on the clock edge that ends the strobe. It is returned together with a one-cycle done pulse, which also marks the end of writes.

Top module: `pbus_timer`

## Requirements
- R1: After reset, chip select, write strobe and read strobe are high (inactive), output enable and direction are low, done is low and ready is high.
- R2: After a request is accepted, chip select is low and both strobes are high for exactly the setup count: bits [31:27] for a write, bits [16:12] for a read. A setup count of 0 makes the strobe start in the first cycle after acceptance.
- R3: The write strobe stays low for the count in bits [26:21] and the read strobe for the count in bits [11:6]. A programmed 0 behaves as 1.
- R4: After the strobe rises, chip select stays low for the hold count: bits [20:17] for a write, bits [5:2] for a read. A programmed 0 behaves as 1.
- R5: After the last hold cycle, chip select is high for gap+1 cycles, where gap is bits [1:0]. Ready is high in the last of those cycles, so a waiting request starts its setup right after them.
- R6: When a read is in its last hold cycle and a read request is waiting, the new read is accepted in that cycle. No gap is inserted and chip select stays low across both accesses. Every other pairing inserts the gap.
- R7: Throughout a write (setup, strobe, hold), output enable and direction are 1, the data bus carries the request's write data and the command line carries its command bit.
- R8: Throughout a read, output enable and direction are 0 and the command line carries the command bit. The read data output takes the value the data input had in the last strobe-low cycle.
- R9: Done is high for exactly one cycle, the cycle right after the last hold cycle of each access.
- R10: A change of the timing word after a request is accepted has no effect on that access's setup, strobe, hold or gap lengths.
- R11: The two strobes are never low together, and a strobe is low only while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock; all counts are in its cycles |
| rst | input | 1 | Synchronous reset, active high |
| cfg_word | input | 32 | Timing word, captured at request acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_rd | input | 1 | 1 = read access, 0 = write access |
| req_cmd | input | 1 | Command/address bit for the access |
| req_wdata | input | DW | Write data |
| rsp_done | output | 1 | One-cycle pulse after an access completes |
| rsp_rdata | output | DW | Data captured at the end of the last read strobe |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_cmd | output | 1 | Command/address line |
| bus_dir | output | 1 | Direction, 1 = write |
| bus_oe | output | 1 | Data output enable, 1 = block drives the data bus |
| bus_dout | output | DW | Data bus value driven during writes |
| bus_din | input | DW | Data bus value seen during reads |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |

## Verification
Single accesses run with random timing words whose fields include zero and full-scale values. Measuring every phase length tells the read field set apart from the write set, and the clamping of width and hold apart from a plain count. The data input changes every strobe cycle, so a capture one cycle early or late gives a wrong read value. Back-to-back pairs in all four read/write orders separate the gap-free read-after-read case from the others. Rewriting the timing word right after acceptance shows whether the block latched it or reads it live.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam int CNT_W = 6;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    // Bit layout of the 32-bit timing word
    localparam int WSU_LSB = 27;
    localparam int WSU_W   = 5;
    localparam int WWD_LSB = 21;
    localparam int WWD_W   = 6;
    localparam int WHD_LSB = 17;
    localparam int WHD_W   = 4;
    localparam int RSU_LSB = 12;
    localparam int RSU_W   = 5;
    localparam int RWD_LSB = 6;
    localparam int RWD_W   = 6;
    localparam int RHD_LSB = 2;
    localparam int RHD_W   = 4;
    localparam int GAP_LSB = 0;
    localparam int GAP_W   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_GAP
    } seq_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] width;
        logic [CNT_W-1:0] hold;
    } phase_t;

    typedef struct packed {
        phase_t           wr;
        phase_t           rd;
        logic [CNT_W-1:0] gap;
    } bus_timing_t;

    function automatic logic [CNT_W-1:0] field(input logic [31:0] w, input int lsb, input int wid);
        logic [31:0] mask;
        mask = (32'd1 << wid) - 32'd1;
        return CNT_W'((w >> lsb) & mask);
    endfunction

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_ONE : v;
    endfunction

    function automatic bus_timing_t unpack_timing(input logic [31:0] w);
        bus_timing_t t;
        t.wr.setup = field(w, WSU_LSB, WSU_W);
        t.wr.width = at_least_one(field(w, WWD_LSB, WWD_W));
        t.wr.hold  = at_least_one(field(w, WHD_LSB, WHD_W));
        t.rd.setup = field(w, RSU_LSB, RSU_W);
        t.rd.width = at_least_one(field(w, RWD_LSB, RWD_W));
        t.rd.hold  = at_least_one(field(w, RHD_LSB, RHD_W));
        t.gap      = field(w, GAP_LSB, GAP_W);
        return t;
    endfunction

endpackage

// File: rtl/pbus_timing_regs.sv
module pbus_timing_regs
    import pbus_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [31:0]          cfg_word,
    input  logic                 load,
    input  logic                 req_rd,
    input  logic                 sel_rd,
    output phase_t               incoming,
    output phase_t               cur,
    output logic [CNT_W-1:0]     gap
);

    bus_timing_t decoded;
    bus_timing_t held_q;

    // Decode and clamp the live word; used only for the first phase of a new access
    always_comb begin
        decoded  = unpack_timing(cfg_word);
        incoming = req_rd ? decoded.rd : decoded.wr;
    end

    // Timing snapshot taken at acceptance
    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= unpack_timing(32'd0);
        end else if (load) begin
            held_q <= decoded;
        end
    end

    assign cur = sel_rd ? held_q.rd : held_q.wr;
    assign gap = held_q.gap;

endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
    import pbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_rd,
    input  logic             cur_rd,
    input  phase_t           incoming,
    input  phase_t           cur,
    input  logic [CNT_W-1:0] gap,
    output logic             req_ready,
    output logic             accept,
    output seq_state_t       state,
    output logic             strobe_last,
    output logic             hold_last
);

    seq_state_t       state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    always_comb begin
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_HOLD: req_ready = cnt_zero && cur_rd && req_rd;
            ST_GAP:  req_ready = cnt_zero;
            default: req_ready = 1'b0;
        endcase
    end

    assign accept = req_valid && req_ready;

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_zero ? cnt_q : (cnt_q - CNT_ONE);
        if (accept) begin
            if (incoming.setup != '0) begin
                state_n = ST_SETUP;
                cnt_n   = incoming.setup - CNT_ONE;
            end else begin
                state_n = ST_STROBE;
                cnt_n   = incoming.width - CNT_ONE;
            end
        end else begin
            unique case (state_q)
                ST_SETUP: if (cnt_zero) begin
                    state_n = ST_STROBE;
                    cnt_n   = cur.width - CNT_ONE;
                end
                ST_STROBE: if (cnt_zero) begin
                    state_n = ST_HOLD;
                    cnt_n   = cur.hold - CNT_ONE;
                end
                ST_HOLD: if (cnt_zero) begin
                    state_n = ST_GAP;
                    cnt_n   = gap;
                end
                ST_GAP: if (cnt_zero) begin
                    state_n = ST_IDLE;
                end
                default: begin
                    state_n = ST_IDLE;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    assign state       = state_q;
    assign strobe_last = (state_q == ST_STROBE) && cnt_zero;
    assign hold_last   = (state_q == ST_HOLD) && cnt_zero;

endmodule

// File: rtl/pbus_pins.sv
module pbus_pins
    import pbus_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          req_rd,
    input  logic          req_cmd,
    input  logic [DW-1:0] req_wdata,
    input  seq_state_t    state,
    input  logic          strobe_last,
    input  logic          hold_last,
    input  logic [DW-1:0] bus_din,
    output logic          cur_rd,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata,
    output logic          bus_cs_n,
    output logic          bus_cmd,
    output logic          bus_dir,
    output logic          bus_oe,
    output logic [DW-1:0] bus_dout,
    output logic          bus_wr_n,
    output logic          bus_rd_n
);

    logic          rd_q;
    logic          cmd_q;
    logic [DW-1:0] wdata_q;
    logic          done_q;
    logic [DW-1:0] rdata_q;
    logic          in_access;
    logic          strobing;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q    <= 1'b0;
            cmd_q   <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            rd_q    <= req_rd;
            cmd_q   <= req_cmd;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= hold_last;
            if (strobe_last && rd_q) begin
                rdata_q <= bus_din;
            end
        end
    end

    assign in_access = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
    assign strobing  = (state == ST_STROBE);

    assign cur_rd    = rd_q;
    assign rsp_done  = done_q;
    assign rsp_rdata = rdata_q;
    assign bus_cs_n  = !in_access;
    assign bus_cmd   = in_access && cmd_q;
    assign bus_dir   = in_access && !rd_q;
    assign bus_oe    = in_access && !rd_q;
    assign bus_dout  = (in_access && !rd_q) ? wdata_q : '0;
    assign bus_wr_n  = !(strobing && !rd_q);
    assign bus_rd_n  = !(strobing && rd_q);

endmodule

// File: rtl/pbus_timer.sv
module pbus_timer
    import pbus_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [31:0]   cfg_word,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_rd,
    input  logic          req_cmd,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata,
    output logic          bus_cs_n,
    output logic          bus_cmd,
    output logic          bus_dir,
    output logic          bus_oe,
    output logic [DW-1:0] bus_dout,
    input  logic [DW-1:0] bus_din,
    output logic          bus_wr_n,
    output logic          bus_rd_n
);

    phase_t           incoming;
    phase_t           cur;
    logic [CNT_W-1:0] gap;
    logic             accept;
    logic             cur_rd;
    seq_state_t       state;
    logic             strobe_last;
    logic             hold_last;

    pbus_timing_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .cfg_word (cfg_word),
        .load     (accept),
        .req_rd   (req_rd),
        .sel_rd   (cur_rd),
        .incoming (incoming),
        .cur      (cur),
        .gap      (gap)
    );

    pbus_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_rd      (req_rd),
        .cur_rd      (cur_rd),
        .incoming    (incoming),
        .cur         (cur),
        .gap         (gap),
        .req_ready   (req_ready),
        .accept      (accept),
        .state       (state),
        .strobe_last (strobe_last),
        .hold_last   (hold_last)
    );

    pbus_pins #(.DW(DW)) u_pins (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .req_rd      (req_rd),
        .req_cmd     (req_cmd),
        .req_wdata   (req_wdata),
        .state       (state),
        .strobe_last (strobe_last),
        .hold_last   (hold_last),
        .bus_din     (bus_din),
        .cur_rd      (cur_rd),
        .rsp_done    (rsp_done),
        .rsp_rdata   (rsp_rdata),
        .bus_cs_n    (bus_cs_n),
        .bus_cmd     (bus_cmd),
        .bus_dir     (bus_dir),
        .bus_oe      (bus_oe),
        .bus_dout    (bus_dout),
        .bus_wr_n    (bus_wr_n),
        .bus_rd_n    (bus_rd_n)
    );

endmodule

// File: rtl/pbus_timer_chk.sv
module pbus_timer_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_done,
    input logic          bus_cs_n,
    input logic          bus_oe,
    input logic          bus_dir,
    input logic [DW-1:0] bus_dout,
    input logic          bus_wr_n,
    input logic          bus_rd_n
);

    // R11
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(!bus_wr_n && !bus_rd_n));

    // R11
    strobe_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr_n || !bus_rd_n) |-> !bus_cs_n);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    // R8
    read_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd_n |-> (!bus_oe && !bus_dir));

    // R7
    write_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_n |-> (bus_oe && bus_dir));

    // R7
    write_data_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && !bus_cs_n && $past(bus_oe) && $past(!bus_cs_n)) |-> $stable(bus_dout));

    // R2
    accept_starts_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !bus_cs_n);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        bus_cs_n |-> (bus_wr_n && bus_rd_n && !bus_oe));

endmodule

bind pbus_timer pbus_timer_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .bus_cs_n  (bus_cs_n),
    .bus_oe    (bus_oe),
    .bus_dir   (bus_dir),
    .bus_dout  (bus_dout),
    .bus_wr_n  (bus_wr_n),
    .bus_rd_n  (bus_rd_n)
);

// File: tb/pbus_timer_tb_top.sv
module pbus_timer_tb_top;

    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [31:0]   cfg_word = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_rd = 1'b0;
    logic          req_cmd = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic          bus_cs_n, bus_cmd, bus_dir, bus_oe, bus_wr_n, bus_rd_n;
    logic [DW-1:0] bus_dout;
    logic [DW-1:0] bus_din = '0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pbus_timer #(.DW(DW)) dut_i (
        .clk(clk), .rst(rst), .cfg_word(cfg_word),
        .req_valid(req_valid), .req_ready(req_ready), .req_rd(req_rd),
        .req_cmd(req_cmd), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_cs_n(bus_cs_n), .bus_cmd(bus_cmd), .bus_dir(bus_dir),
        .bus_oe(bus_oe), .bus_dout(bus_dout), .bus_din(bus_din),
        .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int clamp1(input int v);
        return (v == 0) ? 1 : v;
    endfunction
    function automatic int ex_setup(input logic [31:0] c, input bit rd);
        return rd ? int'(c[16:12]) : int'(c[31:27]);
    endfunction
    function automatic int ex_width(input logic [31:0] c, input bit rd);
        return clamp1(rd ? int'(c[11:6]) : int'(c[26:21]));
    endfunction
    function automatic int ex_hold(input logic [31:0] c, input bit rd);
        return clamp1(rd ? int'(c[5:2]) : int'(c[20:17]));
    endfunction
    function automatic int ex_gap(input logic [31:0] c);
        return int'(c[1:0]) + 1;
    endfunction
    function automatic logic [31:0] mk(input int ws, input int ww, input int wh,
                                       input int rs, input int rw, input int rh, input int g);
        return {5'(ws), 6'(ww), 4'(wh), 5'(rs), 6'(rw), 4'(rh), 2'(g)};
    endfunction
    function automatic logic [DW-1:0] din_at(input int k);
        return DW'(8'h30 + k);
    endfunction

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // One access measured phase by phase
    task automatic xfer(input bit rd, input bit cmd, input logic [DW-1:0] wd,
                        input logic [31:0] cfg, input bit chg);
        int su, wn, hd, gp;
        bit pins_ok, excl_ok, gap_ok;
        @(negedge clk);
        cfg_word = cfg; req_rd = rd; req_cmd = cmd; req_wdata = wd; req_valid = 1'b1;
        #1;
        while (!req_ready) step();
        step();
        req_valid = 1'b0;
        if (chg) cfg_word = ~cfg;
        #1;
        su = 0; wn = 0; hd = 0; gp = 0;
        pins_ok = 1'b1; excl_ok = 1'b1; gap_ok = 1'b1;
        while (!bus_cs_n && (rd ? bus_rd_n : bus_wr_n)) begin
            if (bus_oe !== !rd || bus_dir !== !rd || bus_cmd !== cmd || (!rd && bus_dout !== wd)) pins_ok = 1'b0;
            if (rd ? !bus_wr_n : !bus_rd_n) excl_ok = 1'b0;
            su++;
            step();
        end
        while (!(rd ? bus_rd_n : bus_wr_n)) begin
            if (bus_oe !== !rd || bus_dir !== !rd || bus_cmd !== cmd || (!rd && bus_dout !== wd)) pins_ok = 1'b0;
            if (rd ? !bus_wr_n : !bus_rd_n) excl_ok = 1'b0;
            if (bus_cs_n) excl_ok = 1'b0;
            bus_din = din_at(wn);
            wn++;
            step();
        end
        while (!bus_cs_n) begin
            if (bus_oe !== !rd || bus_dir !== !rd || bus_cmd !== cmd || (!rd && bus_dout !== wd)) pins_ok = 1'b0;
            if (!bus_wr_n || !bus_rd_n) excl_ok = 1'b0;
            hd++;
            step();
        end
        chk("R9 done after hold", int'(rsp_done), 1);
        forever begin
            gp++;
            if (!bus_cs_n) gap_ok = 1'b0;
            if (req_ready) break;
            step();
        end
        chk(chg ? "R2/R10 setup" : "R2 setup", su, ex_setup(cfg, rd));
        chk(chg ? "R3/R10 strobe" : "R3 strobe", wn, ex_width(cfg, rd));
        chk(chg ? "R4/R10 hold" : "R4 hold", hd, ex_hold(cfg, rd));
        chk(chg ? "R5/R10 gap" : "R5 gap", gp, ex_gap(cfg));
        chk("R5 cs high in gap", int'(gap_ok), 1);
        chk(rd ? "R8 pins" : "R7 pins", int'(pins_ok), 1);
        chk("R11 strobes", int'(excl_ok), 1);
        if (rd) chk("R8 rdata", int'(rsp_rdata), int'(din_at(ex_width(cfg, 1'b1) - 1)));
    endtask

    // Two requests presented back to back; measures the first unbroken chip-select run
    task automatic pair(input bit rd1, input bit rd2, input logic [31:0] cfg);
        int run, dones, expect_run;
        bit counting, drop;
        @(negedge clk);
        cfg_word = cfg; req_rd = rd1; req_cmd = 1'b1; req_wdata = 8'h5C; req_valid = 1'b1;
        #1;
        while (!req_ready) step();
        step();
        req_rd = rd2;
        #1;
        run = 0; dones = 0; counting = 1'b1; drop = 1'b0;
        for (int c = 0; c < 4000; c++) begin
            if (rsp_done) dones++;
            if (counting) begin
                if (!bus_cs_n) run++;
                else counting = 1'b0;
            end
            if (dones == 2 && req_ready && !req_valid) break;
            if (req_valid && req_ready) drop = 1'b1;
            step();
            if (drop) begin
                req_valid = 1'b0;
                drop = 1'b0;
                #1;
            end
        end
        expect_run = ex_setup(cfg, rd1) + ex_width(cfg, rd1) + ex_hold(cfg, rd1);
        if (rd1 && rd2)
            expect_run = expect_run + ex_setup(cfg, 1'b1) + ex_width(cfg, 1'b1) + ex_hold(cfg, 1'b1);
        chk((rd1 && rd2) ? "R6 read-read no gap" : "R6 gap kept", run, expect_run);
        chk("R9 two done pulses", dones, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 cs_n", int'(bus_cs_n), 1);
        chk("R1 wr_n", int'(bus_wr_n), 1);
        chk("R1 rd_n", int'(bus_rd_n), 1);
        chk("R1 oe", int'(bus_oe), 0);
        chk("R1 dir", int'(bus_dir), 0);
        chk("R1 done", int'(rsp_done), 0);
        chk("R1 ready", int'(req_ready), 1);

        // Directed corners
        xfer(1'b0, 1'b1, 8'hA5, 32'h0000_0000, 1'b0);      // zero word: clamps, no setup
        xfer(1'b1, 1'b0, 8'h00, 32'h0000_0000, 1'b0);
        xfer(1'b0, 1'b0, 8'h3C, 32'hFFFF_FFFF, 1'b0);      // full scale
        xfer(1'b1, 1'b1, 8'h00, 32'hFFFF_FFFF, 1'b0);
        xfer(1'b0, 1'b1, 8'h96, mk(0, 5, 2, 7, 1, 3, 1), 1'b0);
        xfer(1'b1, 1'b1, 8'h00, mk(9, 1, 4, 0, 6, 1, 2), 1'b0);
        xfer(1'b0, 1'b0, 8'h81, mk(3, 4, 2, 1, 2, 1, 3), 1'b1);  // R10
        xfer(1'b1, 1'b0, 8'h00, mk(1, 2, 1, 4, 3, 2, 0), 1'b1);  // R10

        pair(1'b1, 1'b1, mk(2, 3, 2, 1, 2, 2, 3));
        pair(1'b1, 1'b1, mk(1, 1, 1, 0, 0, 0, 2));
        pair(1'b1, 1'b0, mk(2, 3, 2, 1, 2, 2, 3));
        pair(1'b0, 1'b1, mk(2, 3, 2, 1, 2, 2, 3));
        pair(1'b0, 1'b0, mk(0, 1, 1, 0, 1, 1, 0));

        // Random accesses
        for (int i = 0; i < 40; i++) begin
            logic [31:0] c;
            c = $urandom();
            xfer(1'($urandom()), 1'($urandom()), 8'($urandom()), c, (i % 5) == 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule